// File: doc/BRIEF.md
# Sector Erase Scheduler with Suspend

This block times the erase operations of a NOR-style flash array and owns the erase-related status bits that a status read returns. A command decoder sends it single-cycle pulses: a sector erase request carrying a sector index, a chip erase request, an abort, a suspend, a resume and a status-read strobe. The block does not touch the array and does not decode bus writes. It only schedules the erase and reports on it.

A sector erase runs in two phases. First comes a collection window. Each further sector request restarts the window, so several sectors can be queued into one operation. When the window closes, the erase phase starts. Its duration is a per-sector erase time multiplied by the number of distinct queued sectors.

A suspend stops the operation and saves the time still owed. A resume restarts it from that saved time. While the erase is suspended, the per-sector query still reports which sectors are being erased, so the decoder can steer reads to status or to array data. All times are counted in clock cycles, derived from a cycles-per-microsecond parameter.

Top module: `sector_erase_sched`

## Requirements
- R1: After a synchronous reset, dq7_o, dq3_o, dq2_o, busy_o, susp_o, query_hit_o and done_o are all 0.
- R2: A sector request is accepted when idle and not suspended, or while the window is open. On acceptance the sector is marked in the bitmap, dq7_o is cleared, busy_o is 1 and dq3_o stays 0. The queued count rises only for sectors not already marked. query_hit_o shows the bitmap bit for query_idx, one clock after the bitmap or query_idx changes.
- R3: Each accepted request restarts the collection window of WINDOW_US*CYC_PER_US cycles. dq3_o rises that many clock edges after the edge that accepted the last request.
- R4: When dq3_o rises, the erase countdown is loaded with (CYC_PER_US*US_PER_MS*2^SECT_EXP) times the queued count. done_o is raised that many edges later.
- R5: On completion, done_o is 1 for exactly one cycle, dq7_o is the inverse of its previous value, dq3_o and busy_o are 0, and the bitmap and count are cleared.
- R6: An abort while the window is open returns the block to idle. The bitmap and count are cleared, dq3_o stays 0 and no done_o follows. An abort in any other phase has no effect.
- R7: During the erase phase (dq3_o = 1), sector requests, chip requests and aborts are ignored, and the completion time is unchanged.
- R8: A chip request when idle and not suspended sets busy_o and clears dq7_o, while dq3_o stays 0. done_o follows CYC_PER_US*US_PER_MS*2^CHIP_EXP edges later. Sector requests during a chip erase are ignored.
- R9: A suspend while the window is open saves the full computed erase time. It then clears dq3_o and busy_o, sets susp_o and keeps the bitmap.
- R10: A suspend during the erase phase saves the cycles still left on the countdown, which is at least 1, and stops the countdown.
- R11: A resume while suspended sets dq3_o, clears dq7_o and susp_o, and raises done_o after exactly the saved number of cycles.
- R12: While suspended, sector and chip requests are rejected and busy_o stays 0. A resume when not suspended is ignored.
- R13: A status-read strobe inverts dq2_o when busy_o is 1, or when susp_o is 1 and the queried sector is marked. In every other case dq2_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sect_req | input | 1 | Sector erase request pulse |
| sect_idx | input | IDX_W | Sector index for sect_req |
| chip_req | input | 1 | Chip erase request pulse |
| abort_req | input | 1 | Any other command during the window (abort) |
| susp_req | input | 1 | Erase suspend pulse |
| resume_req | input | 1 | Erase resume pulse |
| stat_rd | input | 1 | Status read strobe |
| query_idx | input | IDX_W | Sector queried for erase membership |
| dq7_o | output | 1 | Completion polarity status bit |
| dq3_o | output | 1 | Erase phase started (window closed) |
| dq2_o | output | 1 | Toggle bit, flips on qualifying status reads |
| busy_o | output | 1 | An erase window, erase or chip erase is running |
| susp_o | output | 1 | A suspended erase is pending |
| query_hit_o | output | 1 | Queried sector is marked for erase |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a suspend that lands on the final cycle of the erase countdown, where the saved time must be 1 and not 0. A saved time of 0 would silently drop the suspended state. The bench gets there by waiting for dq3_o to rise and then counting an exact number of idle cycles before it pulses suspend, sweeping that count up to one short of the full duration. It then measures the resume-to-done latency against the arithmetic remainder. Sweeps over the number of queued sectors and over the request spacing check the window retrigger and the scaled duration.

// File: rtl/ers_pkg.sv
package ers_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_WINDOW = 2'd1,
    PH_ERASE  = 2'd2,
    PH_CHIP   = 2'd3
  } phase_t;
endpackage

// File: rtl/ers_countdown.sv
// Loadable down-counter; expire is high in the last counted cycle.
module ers_countdown #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         halt,
  output logic [W-1:0] cnt,
  output logic         expire
);
  always_ff @(posedge clk) begin
    if (rst || halt) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - W'(1);
    end
  end

  assign expire = (cnt == W'(1));
endmodule

// File: rtl/ers_sector_map.sv
// Bitmap of sectors queued for erase, distinct-sector count, registered query.
module ers_sector_map #(
  parameter int NS  = 8,
  parameter int IW  = 3,
  parameter int CW  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic          clr_all,
  input  logic [IW-1:0] q_idx,
  output logic [NS-1:0] bits,
  output logic [CW-1:0] count,
  output logic          q_hit
);
  logic set_ok;
  logic already;
  logic q_ok;

  assign set_ok  = (32'(set_idx) < NS);
  assign already = set_ok && bits[set_idx];
  assign q_ok    = (32'(q_idx) < NS);

  for (genvar i = 0; i < NS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clr_all) begin
        bits[i] <= 1'b0;
      end else if (set_en && set_idx == IW'(i)) begin
        bits[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      count <= '0;
    end else if (set_en && set_ok && !already) begin
      count <= count + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_hit <= 1'b0;
    end else begin
      q_hit <= q_ok && bits[q_idx];
    end
  end
endmodule

// File: rtl/sector_erase_sched.sv
module sector_erase_sched
  import ers_pkg::*;
#(
  parameter int NUM_SECTORS = 64,
  parameter int CYC_PER_US  = 100,
  parameter int WINDOW_US   = 50,
  parameter int US_PER_MS   = 1000,
  parameter int SECT_EXP    = 9,
  parameter int CHIP_EXP    = 12,
  localparam int IDX_W      = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sect_req,
  input  logic [IDX_W-1:0] sect_idx,
  input  logic             chip_req,
  input  logic             abort_req,
  input  logic             susp_req,
  input  logic             resume_req,
  input  logic             stat_rd,
  input  logic [IDX_W-1:0] query_idx,
  output logic             dq7_o,
  output logic             dq3_o,
  output logic             dq2_o,
  output logic             busy_o,
  output logic             susp_o,
  output logic             query_hit_o,
  output logic             done_o
);
  localparam longint unsigned MS_CYC   = longint'(CYC_PER_US) * longint'(US_PER_MS);
  localparam longint unsigned SECT_CYC = MS_CYC << SECT_EXP;
  localparam longint unsigned CHIP_CYC = MS_CYC << CHIP_EXP;
  localparam longint unsigned WIN_CYC  = longint'(CYC_PER_US) * longint'(WINDOW_US);
  localparam longint unsigned ERS_MAX  = SECT_CYC * longint'(NUM_SECTORS);
  localparam longint unsigned TMR_MAX  = (ERS_MAX > CHIP_CYC) ? ERS_MAX : CHIP_CYC;
  localparam int TMR_W = $clog2(TMR_MAX + 1);
  localparam int WIN_W = $clog2(WIN_CYC + 1);
  localparam int CNT_W = $clog2(NUM_SECTORS + 1);

  phase_t             phase, phase_nxt;
  logic [TMR_W-1:0]   saved_q;
  logic [NUM_SECTORS-1:0] map_bits;
  logic [CNT_W-1:0]   q_count;
  logic [WIN_W-1:0]   win_cnt;
  logic               win_exp;
  logic [TMR_W-1:0]   tmr_cnt;
  logic               tmr_exp;
  logic [TMR_W-1:0]   erase_len;
  logic [TMR_W-1:0]   tmr_load_val;

  logic in_idle, in_win, in_ers, in_chip, suspended;
  logic do_susp_win, do_susp_ers, do_abort;
  logic acc_sect, acc_chip, acc_resume;
  logic win_done, ers_done, chip_done;
  logic q_sel_ok, dq2_flip;

  assign in_idle   = (phase == PH_IDLE);
  assign in_win    = (phase == PH_WINDOW);
  assign in_ers    = (phase == PH_ERASE);
  assign in_chip   = (phase == PH_CHIP);
  assign suspended = (saved_q != '0);

  // Command acceptance, suspend first, then abort, then starts.
  assign do_susp_win = susp_req && in_win;
  assign do_susp_ers = susp_req && in_ers;
  assign do_abort    = abort_req && in_win && !susp_req;
  assign acc_sect    = sect_req && !susp_req && !abort_req &&
                       ((in_idle && !suspended) || in_win);
  assign acc_chip    = chip_req && !sect_req && in_idle && !suspended;
  assign acc_resume  = resume_req && in_idle && suspended;

  assign win_done  = in_win && win_exp && !acc_sect && !do_susp_win && !do_abort;
  assign ers_done  = in_ers && tmr_exp && !do_susp_ers;
  assign chip_done = in_chip && tmr_exp;

  assign erase_len = TMR_W'(SECT_CYC) * TMR_W'(q_count);

  always_comb begin
    tmr_load_val = erase_len;
    if (acc_chip)   tmr_load_val = TMR_W'(CHIP_CYC);
    if (acc_resume) tmr_load_val = saved_q;
  end

  ers_countdown #(.W(WIN_W)) u_win (
    .clk      (clk),
    .rst      (rst),
    .load     (acc_sect),
    .load_val (WIN_W'(WIN_CYC)),
    .halt     (do_susp_win || do_abort || win_done),
    .cnt      (win_cnt),
    .expire   (win_exp)
  );

  ers_countdown #(.W(TMR_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (win_done || acc_chip || acc_resume),
    .load_val (tmr_load_val),
    .halt     (do_susp_ers || ers_done || chip_done),
    .cnt      (tmr_cnt),
    .expire   (tmr_exp)
  );

  ers_sector_map #(.NS(NUM_SECTORS), .IW(IDX_W), .CW(CNT_W)) u_map (
    .clk     (clk),
    .rst     (rst),
    .set_en  (acc_sect),
    .set_idx (sect_idx),
    .clr_all (do_abort || ers_done),
    .q_idx   (query_idx),
    .bits    (map_bits),
    .count   (q_count),
    .q_hit   (query_hit_o)
  );

  always_comb begin
    phase_nxt = phase;
    unique case (phase)
      PH_IDLE: begin
        if (acc_sect)        phase_nxt = PH_WINDOW;
        else if (acc_chip)   phase_nxt = PH_CHIP;
        else if (acc_resume) phase_nxt = PH_ERASE;
      end
      PH_WINDOW: begin
        if (do_susp_win || do_abort) phase_nxt = PH_IDLE;
        else if (win_done)           phase_nxt = PH_ERASE;
      end
      PH_ERASE: begin
        if (do_susp_ers || ers_done) phase_nxt = PH_IDLE;
      end
      PH_CHIP: begin
        if (chip_done) phase_nxt = PH_IDLE;
      end
      default: phase_nxt = PH_IDLE;
    endcase
  end

  assign q_sel_ok = (32'(query_idx) < NUM_SECTORS) && map_bits[query_idx];
  assign dq2_flip = stat_rd && (!in_idle || (suspended && q_sel_ok));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      saved_q <= '0;
      dq7_o   <= 1'b0;
      dq3_o   <= 1'b0;
      dq2_o   <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      phase  <= phase_nxt;
      dq3_o  <= (phase_nxt == PH_ERASE);
      done_o <= ers_done || chip_done;
      if (do_susp_win)      saved_q <= erase_len;
      else if (do_susp_ers) saved_q <= tmr_cnt;
      else if (acc_resume)  saved_q <= '0;
      if (acc_sect || acc_chip || acc_resume) dq7_o <= 1'b0;
      else if (ers_done || chip_done)         dq7_o <= ~dq7_o;
      if (dq2_flip) dq2_o <= ~dq2_o;
    end
  end

  assign busy_o = !in_idle;
  assign susp_o = suspended;
endmodule

// File: rtl/sched_chk.sv
module sched_chk (
  input logic clk,
  input logic rst,
  input logic sect_req,
  input logic chip_req,
  input logic resume_req,
  input logic dq7_o,
  input logic dq3_o,
  input logic busy_o,
  input logic susp_o,
  input logic done_o
);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R5
  done_flip_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (dq7_o != $past(dq7_o)) && !dq3_o && !busy_o);
  // R4
  dq3_busy_chk: assert property (@(posedge clk) disable iff (rst)
    dq3_o |-> busy_o);
  // R9
  susp_dq3_chk: assert property (@(posedge clk) disable iff (rst)
    susp_o |-> !dq3_o && !busy_o);
  // R11
  resume_go_chk: assert property (@(posedge clk) disable iff (rst)
    (resume_req && susp_o && !busy_o) |=> dq3_o && !dq7_o && !susp_o);
  // R12
  susp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (susp_o && !resume_req) |=> !busy_o && susp_o);
  // R8
  chip_start_chk: assert property (@(posedge clk) disable iff (rst)
    (chip_req && !sect_req && !busy_o && !susp_o) |=> busy_o && !dq3_o && !dq7_o);
endmodule

bind sector_erase_sched sched_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .sect_req   (sect_req),
  .chip_req   (chip_req),
  .resume_req (resume_req),
  .dq7_o      (dq7_o),
  .dq3_o      (dq3_o),
  .busy_o     (busy_o),
  .susp_o     (susp_o),
  .done_o     (done_o)
);

// File: tb/sim_sector_erase_sched.sv
module sim_sector_erase_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NS   = 4;
  localparam int WIN  = 5;               // WINDOW_US=5, CYC_PER_US=1
  localparam int SECT = 1 * 2 * (1 << 2); // 8 cycles per sector
  localparam int CHIP = 1 * 2 * (1 << 3); // 16 cycles

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sect_req = 0, chip_req = 0, abort_req = 0, susp_req = 0, resume_req = 0, stat_rd = 0;
  logic [1:0] sect_idx = '0, query_idx = '0;
  logic dq7_o, dq3_o, dq2_o, busy_o, susp_o, query_hit_o, done_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sector_erase_sched #(
    .NUM_SECTORS(NS), .CYC_PER_US(1), .WINDOW_US(WIN),
    .US_PER_MS(2), .SECT_EXP(2), .CHIP_EXP(3)
  ) u0 (.*);

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic p_sect(int idx);
    sect_idx = 2'(idx); sect_req = 1; tick(); sect_req = 0;
  endtask
  task automatic p_chip();   chip_req = 1;   tick(); chip_req = 0;   endtask
  task automatic p_abort();  abort_req = 1;  tick(); abort_req = 0;  endtask
  task automatic p_susp();   susp_req = 1;   tick(); susp_req = 0;   endtask
  task automatic p_resume(); resume_req = 1; tick(); resume_req = 0; endtask
  task automatic p_rd();     stat_rd = 1;    tick(); stat_rd = 0;    endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done_o && n < 400) begin tick(); n++; end
  endtask
  task automatic wait_dq3(output int n);
    n = 0;
    while (!dq3_o && n < 400) begin tick(); n++; end
  endtask

  task automatic hit(int idx, int exp, string tag);
    query_idx = 2'(idx); tick();
    chk(tag, query_hit_o, exp);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int n, d, m;
    logic old;
    repeat (3) tick();
    rst = 0;
    tick();
    // R1 reset state
    chk("R1 dq7", dq7_o, 0); chk("R1 dq3", dq3_o, 0); chk("R1 dq2", dq2_o, 0);
    chk("R1 busy", busy_o, 0); chk("R1 susp", susp_o, 0);
    chk("R1 hit", query_hit_o, 0); chk("R1 done", done_o, 0);

    // Sweep number of queued sectors
    for (int k = 1; k <= NS; k++) begin
      for (int s = 0; s < k; s++) begin
        p_sect(s);
        if (s == 0) begin
          chk("R2 dq7 cleared", dq7_o, 0);
          chk("R2 busy", busy_o, 1);
          chk("R2 dq3 low", dq3_o, 0);
        end
        if (s != k - 1) begin
          tick(); tick();
        end
      end
      wait_dq3(n);
      chk("R3 window", n, WIN);
      hit(0, 1, "R2 query marked");
      if (k < NS) hit(NS - 1, 0, "R2 query unmarked");
      wait_done(d);
      d = d + ((k < NS) ? 2 : 1);
      chk("R4 duration", d, SECT * k);
      chk("R5 dq7 flip", dq7_o, 1);
      chk("R5 dq3", dq3_o, 0);
      chk("R5 busy", busy_o, 0);
      tick();
      chk("R5 done pulse", done_o, 0);
      hit(0, 0, "R5 map cleared");
    end

    // Duplicate sector counted once; retrigger gap sweep
    for (int g = 0; g < WIN - 1; g++) begin
      p_sect(1);
      repeat (g) tick();
      p_sect(1);
      wait_dq3(n);
      chk("R3 retrigger", n, WIN);
      wait_done(d);
      chk("R2 distinct count", d, SECT);
      tick();
    end

    // Abort during window
    p_sect(2);
    p_abort();
    chk("R6 busy", busy_o, 0);
    chk("R6 dq3", dq3_o, 0);
    hit(2, 0, "R6 map cleared");
    wait_done(d);
    chk("R6 no done", d, 400);

    // Ignored writes during erase phase
    p_sect(0);
    wait_dq3(n);
    p_sect(3); p_abort(); p_chip();
    wait_done(d);
    chk("R7 duration", d + 3, SECT);
    tick();
    hit(3, 0, "R7 no add");
    p_abort();
    chk("R6 abort idle noop", busy_o, 0);

    // Chip erase
    p_chip();
    chk("R8 busy", busy_o, 1); chk("R8 dq7", dq7_o, 0); chk("R8 dq3", dq3_o, 0);
    p_sect(1);
    wait_done(d);
    chk("R8 duration", d + 1, CHIP);
    tick();
    hit(1, 0, "R8 sect ignored");

    // dq2 behaviour
    old = dq2_o; p_rd();
    chk("R13 idle hold", dq2_o, old);
    p_chip();
    old = dq2_o; p_rd();
    chk("R13 busy toggle", dq2_o, !old);
    p_rd();
    chk("R13 busy toggle2", dq2_o, old);
    wait_done(d);
    tick();

    // Suspend during window
    p_sect(0); p_sect(1);
    p_susp();
    chk("R9 susp", susp_o, 1); chk("R9 busy", busy_o, 0); chk("R9 dq3", dq3_o, 0);
    hit(1, 1, "R9 map kept");
    p_sect(3); p_chip();
    chk("R12 reject busy", busy_o, 0);
    hit(3, 0, "R12 reject map");
    query_idx = 2'd1; old = dq2_o; p_rd();
    chk("R13 susp marked toggle", dq2_o, !old);
    query_idx = 2'd2; old = dq2_o; p_rd();
    chk("R13 susp unmarked hold", dq2_o, old);
    p_resume();
    chk("R11 dq3", dq3_o, 1); chk("R11 dq7", dq7_o, 0); chk("R11 susp", susp_o, 0);
    wait_done(d);
    chk("R9 saved full time", d, 2 * SECT);
    tick();

    // Suspend during erase phase, sweep remaining time down to 1
    for (int mm = 0; mm < 2 * SECT; mm += 5) begin
      m = (mm > 2 * SECT - 1) ? 2 * SECT - 1 : mm;
      p_sect(0); p_sect(2);
      wait_dq3(n);
      repeat (m) tick();
      p_susp();
      chk("R10 susp", susp_o, 1);
      p_resume();
      wait_done(d);
      chk("R10 remaining", d, 2 * SECT - m);
      tick();
    end
    p_sect(0); p_sect(2);
    wait_dq3(n);
    repeat (2 * SECT - 1) tick();
    p_susp();
    chk("R10 min one susp", susp_o, 1);
    p_resume();
    wait_done(d);
    chk("R10 min one", d, 1);
    tick();

    // Resume when not suspended
    p_resume();
    chk("R12 resume ignored busy", busy_o, 0);
    chk("R12 resume ignored dq3", dq3_o, 0);

    finished = 1;
    summary();
    $finish;
  end
endmodule